// File: doc/BRIEF.md
# Prescaled General-Purpose Timer Unit

This block divides the system clock into a periodic tick with a single shared prescaler and feeds that tick to a parameterized set of down-counting timers. Each timer has three registers: a preset register, a live count register and a control word. The control word enables the timer, chooses what happens when the count runs out, and carries a load command. When a timer runs out, it raises a one-cycle interrupt pulse on its own output line.

Software reaches all registers over a simple word-addressed read/write bus. Writes take effect on the clock edge. Read data appears one cycle after the request. With the default parameters, a 250 MHz clock gives a 1 MHz tick.

Top module: `gp_timer_unit`

## Requirements
- R1: After reset the scaler value and scaler reload both hold CLK_HZ/TICK_HZ-1 (249 by default). Every timer count, preset and control word is 0, and every irq line is low.
- R2: While at least one timer is enabled, the scaler decrements on every clock. When it is at 0 it reloads from the scaler reload register and issues one tick, so ticks come every reload+1 clocks.
- R3: An enabled timer (control bit 0 = 1) decrements its count once per tick. A tick that arrives while the count is 0 is an underflow.
- R4: With control bit 1 = 1 (reload mode), an underflow copies the preset into the count and counting goes on. Interrupts then repeat every (preset+1)*(scaler reload+1) clocks.
- R5: With control bit 1 = 0 (stop mode), an underflow leaves the count at 0 and clears control bit 0. Only one interrupt is raised.
- R6: Each underflow drives that timer's irq bit high for exactly one clock, in the cycle after the underflow edge, unless underflows occur on consecutive ticks.
- R7: Writing a control word with bit 2 = 1 copies the preset into the count. Writing bit 2 = 0 leaves the count unchanged. Bit 2 always reads back as 0.
- R8: When a load command and a tick arrive in the same cycle, the load wins: the count equals the preset, not the preset minus one.
- R9: While control bit 0 is 0 the count holds its value. While every timer is disabled, the scaler value also holds.
- R10: The word address selects the register. Address 0 is the scaler value and address 1 is the scaler reload. Timer n sits at 4+4n, with +0 the count, +1 the preset and +2 the control word. Bits 1:0 of the control readback are the current enable and reload state. Read data is valid one clock after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after a read request |
| irq | output | NUM_TIMERS | Per-timer underflow pulse |

## Verification
A scaler that reloads wrongly or ticks while idle shows up directly in the gap between interrupt pulses. The measurement is exact to the cycle after two pulses, and it catches an off-by-one in the reload. A count that decrements while disabled, or a load that loses to a tick, shows up at the next readback of the count register, which is two cycles after the faulty edge. A stop-mode enable that fails to clear shows up within one more tick, as a second pulse and as a nonzero enable bit in the control readback.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    // Register index within a 4-word block
    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_PRESET = 2'd1,
        REG_CTRL   = 2'd2,
        REG_SPARE  = 2'd3
    } gpt_reg_e;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_RL_BIT = 1;
    localparam int CTRL_LD_BIT = 2;

    typedef struct packed {
        logic reload;
        logic enable;
    } gpt_mode_t;

    typedef struct packed {
        logic wr_count;
        logic wr_preset;
        logic wr_ctrl;
    } gpt_wr_t;

    function automatic gpt_mode_t mode_from_word(input logic [2:0] w);
        gpt_mode_t m;
        m.enable = w[CTRL_EN_BIT];
        m.reload = w[CTRL_RL_BIT];
        return m;
    endfunction

    function automatic gpt_wr_t decode_wr(input logic hit, input logic [1:0] sel);
        gpt_wr_t d;
        d.wr_count  = hit && (sel == REG_COUNT);
        d.wr_preset = hit && (sel == REG_PRESET);
        d.wr_ctrl   = hit && (sel == REG_CTRL);
        return d;
    endfunction

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int PS_W         = 16,
    parameter int RESET_RELOAD = 249
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            wr_value,
    input  logic            wr_reload,
    input  logic [PS_W-1:0] wdata,
    output logic [PS_W-1:0] value,
    output logic [PS_W-1:0] reload,
    output logic            tick
);
    localparam logic [PS_W-1:0] RST_VAL = PS_W'(RESET_RELOAD);

    assign tick = run && (value == '0) && !wr_value;

    always_ff @(posedge clk) begin
        if (rst) begin
            value  <= RST_VAL;
            reload <= RST_VAL;
        end else begin
            if (wr_reload)
                reload <= wdata;
            if (wr_value)
                value <= wdata;
            else if (run)
                value <= (value == '0) ? reload : value - PS_W'(1);
        end
    end
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
    import gpt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  gpt_wr_t           wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] preset,
    output gpt_mode_t         mode,
    output logic              underflow,
    output logic              irq
);
    logic load_cmd;

    assign load_cmd  = wr.wr_ctrl && wdata[CTRL_LD_BIT];
    assign underflow = tick && mode.enable && (count == '0) && !load_cmd && !wr.wr_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            preset <= '0;
            mode   <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= underflow;
            if (wr.wr_preset)
                preset <= wdata;

            if (load_cmd)
                count <= preset;
            else if (wr.wr_count)
                count <= wdata;
            else if (tick && mode.enable) begin
                if (count == '0) begin
                    if (mode.reload)
                        count <= preset;
                end else begin
                    count <= count - DATA_W'(1);
                end
            end

            if (wr.wr_ctrl)
                mode <= mode_from_word(wdata[2:0]);
            else if (underflow && !mode.reload)
                mode.enable <= 1'b0;
        end
    end
endmodule

// File: rtl/gpt_readback.sv
module gpt_readback
    import gpt_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int DATA_W     = 32,
    parameter int PS_W       = 16,
    parameter int BLK_W      = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                rd_en,
    input  logic [BLK_W-1:0]                    blk,
    input  logic [1:0]                          reg_sel,
    input  logic [PS_W-1:0]                     ps_value,
    input  logic [PS_W-1:0]                     ps_reload,
    input  logic [NUM_TIMERS-1:0][DATA_W-1:0]   cnt_all,
    input  logic [NUM_TIMERS-1:0][DATA_W-1:0]   preset_all,
    input  logic [NUM_TIMERS-1:0][1:0]          mode_all,
    output logic [DATA_W-1:0]                   rdata
);
    logic [DATA_W-1:0] mux;

    always_comb begin
        mux = '0;
        if (blk == '0) begin
            case (reg_sel)
                REG_COUNT:  mux = DATA_W'(ps_value);
                REG_PRESET: mux = DATA_W'(ps_reload);
                default:    mux = '0;
            endcase
        end
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (blk == BLK_W'(i + 1)) begin
                case (reg_sel)
                    REG_COUNT:  mux = cnt_all[i];
                    REG_PRESET: mux = preset_all[i];
                    REG_CTRL:   mux = DATA_W'(mode_all[i]);
                    default:    mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= mux;
    end
endmodule

// File: rtl/gp_timer_unit.sv
module gp_timer_unit
    import gpt_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int DATA_W     = 32,
    parameter int PS_W       = 16,
    parameter int ADDR_W     = 6,
    parameter int CLK_HZ     = 250_000_000,
    parameter int TICK_HZ    = 1_000_000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_TIMERS-1:0] irq
);
    localparam int BLK_W    = ADDR_W - 2;
    localparam int PS_RESET = CLK_HZ / TICK_HZ - 1;

    logic [BLK_W-1:0] blk;
    logic [1:0]       reg_sel;
    logic             wr_any;

    assign blk     = bus_addr[ADDR_W-1:2];
    assign reg_sel = bus_addr[1:0];
    assign wr_any  = bus_sel && bus_wr;

    logic            tick;
    logic            run;
    logic            ps_wr_value;
    logic            ps_wr_reload;
    logic [PS_W-1:0] ps_value;
    logic [PS_W-1:0] ps_reload;

    assign ps_wr_value  = wr_any && (blk == '0) && (reg_sel == REG_COUNT);
    assign ps_wr_reload = wr_any && (blk == '0) && (reg_sel == REG_PRESET);

    gpt_prescaler #(.PS_W(PS_W), .RESET_RELOAD(PS_RESET)) u_prescaler (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .wr_value (ps_wr_value),
        .wr_reload(ps_wr_reload),
        .wdata    (bus_wdata[PS_W-1:0]),
        .value    (ps_value),
        .reload   (ps_reload),
        .tick     (tick)
    );

    logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt_all;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] preset_all;
    logic [NUM_TIMERS-1:0][1:0]        mode_all;
    logic [NUM_TIMERS-1:0]             en_vec;
    logic [NUM_TIMERS-1:0]             rl_vec;
    logic [NUM_TIMERS-1:0]             ctrl_wr_vec;
    logic [NUM_TIMERS-1:0]             cnt_wr_vec;
    logic [NUM_TIMERS-1:0]             uf_vec;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_ch
        gpt_wr_t   wr_g;
        gpt_mode_t mode_g;

        assign wr_g = decode_wr(wr_any && (blk == BLK_W'(g + 1)), reg_sel);

        gpt_channel #(.DATA_W(DATA_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .wr       (wr_g),
            .wdata    (bus_wdata),
            .count    (cnt_all[g]),
            .preset   (preset_all[g]),
            .mode     (mode_g),
            .underflow(uf_vec[g]),
            .irq      (irq[g])
        );

        assign mode_all[g]    = mode_g;
        assign en_vec[g]      = mode_g.enable;
        assign rl_vec[g]      = mode_g.reload;
        assign ctrl_wr_vec[g] = wr_g.wr_ctrl;
        assign cnt_wr_vec[g]  = wr_g.wr_count;
    end

    assign run = |en_vec;

    gpt_readback #(
        .NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .PS_W(PS_W), .BLK_W(BLK_W)
    ) u_readback (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (bus_sel && !bus_wr),
        .blk       (blk),
        .reg_sel   (reg_sel),
        .ps_value  (ps_value),
        .ps_reload (ps_reload),
        .cnt_all   (cnt_all),
        .preset_all(preset_all),
        .mode_all  (mode_all),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/gpt_timer_checker.sv
module gpt_timer_checker #(
    parameter int NUM_TIMERS = 2,
    parameter int DATA_W     = 32,
    parameter int PS_W       = 16
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              tick,
    input logic                              run,
    input logic [PS_W-1:0]                   ps_value,
    input logic                              ps_wr,
    input logic [NUM_TIMERS-1:0][DATA_W-1:0] cnt,
    input logic [NUM_TIMERS-1:0]             en,
    input logic [NUM_TIMERS-1:0]             rl,
    input logic [NUM_TIMERS-1:0]             ctrl_wr,
    input logic [NUM_TIMERS-1:0]             cnt_wr,
    input logic [NUM_TIMERS-1:0]             uf,
    input logic [NUM_TIMERS-1:0]             irq
);
    p_tick_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        tick |-> (ps_value == '0 && run));

    p_scaler_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (!run && !ps_wr) |=> $stable(ps_value));

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
        p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> $past(tick && en[i] && cnt[i] == '0));

        p_stop_clears_en_r5: assert property (@(posedge clk) disable iff (rst)
            (uf[i] && !rl[i] && !ctrl_wr[i]) |=> !en[i]);

        p_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (!en[i] && !ctrl_wr[i] && !cnt_wr[i]) |=> $stable(cnt[i]));

        p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
            (tick && en[i] && cnt[i] != '0 && !ctrl_wr[i] && !cnt_wr[i])
            |=> (cnt[i] == $past(cnt[i]) - DATA_W'(1)));
    end
endmodule

bind gp_timer_unit gpt_timer_checker #(
    .NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .PS_W(PS_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run     (run),
    .ps_value(ps_value),
    .ps_wr   (ps_wr_value),
    .cnt     (cnt_all),
    .en      (en_vec),
    .rl      (rl_vec),
    .ctrl_wr (ctrl_wr_vec),
    .cnt_wr  (cnt_wr_vec),
    .uf      (uf_vec),
    .irq     (irq)
);

// File: tb/gp_timer_unit_tb_top.sv
module gp_timer_unit_tb_top;
    localparam int NT = 2;
    localparam int DW = 32;
    localparam int AW = 6;

    localparam logic [AW-1:0] A_SCV = 6'd0;
    localparam logic [AW-1:0] A_SCR = 6'd1;
    localparam logic [AW-1:0] A_T0  = 6'd4;
    localparam logic [AW-1:0] A_T1  = 6'd8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NT-1:0] irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
        bit            check;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gp_timer_unit dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        sb_item_t it;
        it.exp = e; it.tag = tag; it.check = 1'b1;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
        sb_item_t it;
        it.exp = '0; it.tag = ""; it.check = 1'b0;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    // Monitor: a read accepted at a rising edge is compared at the next falling edge
    initial begin
        forever begin
            @(posedge clk);
            if (bus_sel && !bus_wr) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10 scoreboard empty", 0, 1);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    if (it.check)
                        check(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wait_irq(input int idx, input int lim, input string tag, output int t);
        int n = 0;
        while (!irq[idx] && n < lim) begin
            @(negedge clk);
            n++;
        end
        if (!irq[idx]) check(1'b0, tag, 0, 1);
        t = cyc;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t1, t2, extra;
        logic [DW-1:0] a, b, sa, sb2;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(irq == '0, "R1 irq after reset", irq, 0);
        bus_read(A_SCR, 249, "R1 scaler reload reset");
        bus_read(A_SCV, 249, "R1 scaler value reset");
        bus_read(A_T0 + 0, 0, "R1 timer0 count reset");
        bus_read(A_T1 + 2, 0, "R1 timer1 ctrl reset");
        @(negedge clk);

        // R2/R4 default scaler: preset 0 in reload mode gives one irq per tick
        bus_write(A_T0 + 1, 0);
        bus_write(A_T0 + 2, 32'h7);
        wait_irq(0, 600, "R2 first irq", t1);
        @(negedge clk);
        wait_irq(0, 600, "R2 second irq", t2);
        check(t2 - t1 == 250, "R2 tick period default", t2 - t1, 250);
        bus_write(A_T0 + 2, 0);

        // R10 scaler registers written and read back
        bus_write(A_SCR, 3);
        bus_write(A_SCV, 3);
        bus_read(A_SCR, 3, "R10 scaler reload readback");
        @(negedge clk);

        // R4 reload mode on timer1: period (2+1)*(3+1) = 12
        bus_write(A_T1 + 1, 2);
        bus_write(A_T1 + 2, 32'h7);
        bus_read(A_T1 + 2, 3, "R7 load bit reads zero, R10 mode bits");
        @(negedge clk);
        wait_irq(1, 100, "R4 first irq", t1);
        @(negedge clk);
        check(irq[1] == 1'b0, "R6 pulse width one cycle", irq[1], 0);
        wait_irq(1, 100, "R4 second irq", t2);
        check(t2 - t1 == 12, "R4 reload period", t2 - t1, 12);
        bus_write(A_T1 + 2, 0);

        // R5 stop mode on timer0
        bus_write(A_T0 + 1, 1);
        bus_write(A_T0 + 2, 32'h5);
        wait_irq(0, 100, "R5 stop irq", t1);
        @(negedge clk);
        extra = 0;
        for (int k = 0; k < 40; k++) begin
            if (irq[0]) extra++;
            @(negedge clk);
        end
        check(extra == 0, "R5 single irq in stop mode", extra, 0);
        bus_read(A_T0 + 2, 0, "R5 enable cleared");
        bus_read(A_T0 + 0, 0, "R5 count stays zero");
        @(negedge clk);

        // R3/R9 counting then freeze
        bus_write(A_T0 + 1, 1000);
        bus_write(A_T0 + 2, 32'h7);
        repeat (20) @(negedge clk);
        bus_write(A_T0 + 2, 32'h2);
        bus_peek(A_T0 + 0, a);
        bus_peek(A_SCV, sa);
        check(a < 1000 && a >= 990, "R3 decrements once per tick", a, 995);
        repeat (20) @(negedge clk);
        bus_peek(A_T0 + 0, b);
        bus_peek(A_SCV, sb2);
        check(a == b, "R9 count frozen when disabled", b, a);
        check(sa == sb2, "R9 scaler frozen when all disabled", sb2, sa);

        // R7 load without enable; writing bit2 = 0 has no effect
        bus_write(A_T0 + 2, 32'h4);
        bus_read(A_T0 + 0, 1000, "R7 load copies preset");
        bus_write(A_T0 + 0, 50);
        bus_write(A_T0 + 2, 32'h0);
        bus_read(A_T0 + 0, 50, "R7 bit2 zero leaves count, R10 count write");
        @(negedge clk);

        // R8 load wins over a same-cycle tick (tick every clock)
        bus_write(A_SCR, 0);
        bus_write(A_SCV, 0);
        bus_write(A_T0 + 1, 100);
        bus_write(A_T0 + 2, 32'h3);
        repeat (5) @(negedge clk);
        bus_write(A_T0 + 2, 32'h7);
        bus_read(A_T0 + 0, 100, "R8 load priority over tick");
        @(negedge clk);
        bus_write(A_T0 + 2, 0);
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule